// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a clocked host and an external asynchronous static RAM that has one shared data bus for both directions. The RAM has a 20-bit word address, a 4-bit data bus, and three active-low strobes: select, write and output enable. The host issues one word at a time on a valid/ready port, with an address, a write flag and write data. Each read returns its data with a single-cycle valid pulse. On the memory side the block drives the address and the strobes, drives the bus through a separate enable, and samples the data the RAM returns.

Every phase length is a clock count. Each count is derived at elaboration by rounding up a nanosecond figure divided by the clock period. One parameter chooses how a write treats output enable. The block can raise output enable before the write and wait for the RAM to release the bus. It can also hold output enable low and let the falling write strobe release the bus. In that case the strobe has to stay low longer. In neither case does the controller drive the bus while the RAM may still drive it.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is held, select, write and output enable are high, the bus drivers are off, the read-valid pulse is low and ready is high.
- R2: Ready is high only in idle. Ready is low on every cycle in which select is low. A request is taken on a clock edge where valid and ready are both high, and a new request may be taken on the edge right after the cycle that shows a read-valid pulse.
- R3: A read holds select and output enable low and write high for exactly RD cycles (2 with the defaults). The bus is sampled on the last of those cycles, and the read-valid pulse lasts one cycle. That pulse is visible RD cycles after the accepting edge.
- R4: With the output-enable-high write mode, output enable stays high for the whole write. Select is low with write high for TURN cycles (1 with the defaults) before write falls. Write then stays low for exactly 1 cycle with the defaults.
- R5: With the output-enable-low write mode, output enable stays low for the whole write. Write is low for TURN+STRB cycles (2 with the defaults), and the drivers switch on only after the first TURN of those cycles.
- R6: The drivers are on only while write is low, the driven value is stable while they stay on, and they are still on in the last write-low cycle (data setup to the end of the write).
- R7: The drivers are never on while select is low, write is high and output enable is low (the RAM's read mode).
- R8: After a write ends, select stays high for at least REC+1 consecutive cycles (2 with the defaults) before the next access.
- R9: A read of an address returns the value last written there, at any address from 0x00000 to 0xFFFFF.
- R10: The address is stable on every cycle in which select stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | 4 | Read data |
| ram_addr | output | 20 | RAM address |
| ram_cs_n | output | 1 | RAM select, active low |
| ram_we_n | output | 1 | RAM write strobe, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_dq_out | output | 4 | Data toward the RAM |
| ram_dq_oe | output | 1 | Enable for the bus drivers |
| ram_dq_in | input | 4 | Data sampled from the RAM |

## Verification
A read response and the acceptance of the next request can fall in the same cycle. Ready comes back high in the very cycle that carries the read-valid pulse. The bench provokes this by queuing a request behind a read, so that the request waits with valid high. It judges the overlap by the response data and its cycle, and by seeing select fall on the edge right after the pulse. A second overlap happens at the bus turnaround when a write follows a read directly. The bench's RAM model gives wrong data until the access time has elapsed. It also flags any cycle in which both sides would drive the bus.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_WTURN,
        ST_WSTRB,
        ST_WREC
    } ctrl_st_e;

    // integer ceiling division for deriving cycle counts
    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample,
    input  logic [DATA_W-1:0] din,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d     = cap_q;
        cap_d.vld = sample;
        if (sample) begin
            cap_d.data = din;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else begin
            cap_q <= cap_d;
        end
    end

    assign rsp_valid = cap_q.vld;
    assign rsp_data  = cap_q.data;
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
    import sram_ctrl_pkg::*;
#(
    parameter int ADDR_W      = 20,
    parameter int DATA_W      = 4,
    parameter int CLK_PS      = 8000,
    parameter int T_ACC_PS    = 10000,
    parameter int T_OFF_PS    = 5000,
    parameter int T_WP_PS     = 7000,
    parameter int T_WP_OEL_PS = 10000,
    parameter int T_DSU_PS    = 5000,
    parameter int T_REC_PS    = 3000,
    parameter bit WR_OE_LOW   = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] ram_addr,
    output logic              ram_cs_n,
    output logic              ram_we_n,
    output logic              ram_oe_n,
    output logic [DATA_W-1:0] ram_dq_out,
    output logic              ram_dq_oe,
    input  logic [DATA_W-1:0] ram_dq_in
);
    // phase lengths in clocks, each rounded up and at least one
    localparam int RD_CYC   = imax(cdiv(T_ACC_PS, CLK_PS), 1);
    localparam int TURN_CYC = imax(cdiv(T_OFF_PS, CLK_PS), 1);
    localparam int WP_CYC   = imax(cdiv(T_WP_PS, CLK_PS), 1);
    localparam int WPO_CYC  = imax(cdiv(T_WP_OEL_PS, CLK_PS), 1);
    localparam int DSU_CYC  = imax(cdiv(T_DSU_PS, CLK_PS), 1);
    localparam int REC_CYC  = imax(cdiv(T_REC_PS, CLK_PS), 1);
    // with OE low the turnaround already counts toward the strobe width
    localparam int STRB_CYC = WR_OE_LOW ? imax(imax(WPO_CYC - TURN_CYC, DSU_CYC), 1)
                                        : imax(WP_CYC, DSU_CYC);
    localparam int MAX_CYC  = imax(imax(RD_CYC, TURN_CYC), imax(STRB_CYC, REC_CYC));
    localparam int CNT_W    = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctrl_st_e          st;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              cs_n;
        logic              we_n;
        logic              oe_n;
        logic              dq_oe;
    } ctl_t;

    localparam ctl_t CTL_RST = '{st: ST_IDLE, addr: '0, wdata: '0,
                                 cs_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

    ctl_t             ctl_d, ctl_q;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    logic             rd_sample;

    sram_phase_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    always_comb begin
        ctl_d     = ctl_q;
        tmr_load  = 1'b0;
        tmr_val   = '0;
        rd_sample = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.addr = req_addr;
                    ctl_d.cs_n = 1'b0;
                    tmr_load   = 1'b1;
                    if (req_write) begin
                        ctl_d.st    = ST_WTURN;
                        ctl_d.wdata = req_wdata;
                        ctl_d.oe_n  = !WR_OE_LOW;
                        ctl_d.we_n  = !WR_OE_LOW;
                        tmr_val     = CNT_W'(TURN_CYC - 1);
                    end else begin
                        ctl_d.st   = ST_RD;
                        ctl_d.oe_n = 1'b0;
                        tmr_val    = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_RD: begin
                if (tmr_done) begin
                    rd_sample  = 1'b1;
                    ctl_d.st   = ST_IDLE;
                    ctl_d.cs_n = 1'b1;
                    ctl_d.oe_n = 1'b1;
                end
            end
            ST_WTURN: begin
                if (tmr_done) begin
                    ctl_d.st    = ST_WSTRB;
                    ctl_d.we_n  = 1'b0;
                    ctl_d.dq_oe = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(STRB_CYC - 1);
                end
            end
            ST_WSTRB: begin
                if (tmr_done) begin
                    ctl_d.st    = ST_WREC;
                    ctl_d.we_n  = 1'b1;
                    ctl_d.cs_n  = 1'b1;
                    ctl_d.oe_n  = 1'b1;
                    ctl_d.dq_oe = 1'b0;
                    tmr_load    = 1'b1;
                    tmr_val     = CNT_W'(REC_CYC - 1);
                end
            end
            ST_WREC: begin
                if (tmr_done) begin
                    ctl_d.st = ST_IDLE;
                end
            end
            default: ctl_d = CTL_RST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= CTL_RST;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sram_rd_capture #(.DATA_W(DATA_W)) i_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample    (rd_sample),
        .din       (ram_dq_in),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_rdata)
    );

    assign req_ready  = (ctl_q.st == ST_IDLE);
    assign ram_addr   = ctl_q.addr;
    assign ram_cs_n   = ctl_q.cs_n;
    assign ram_we_n   = ctl_q.we_n;
    assign ram_oe_n   = ctl_q.oe_n;
    assign ram_dq_out = ctl_q.wdata;
    assign ram_dq_oe  = ctl_q.dq_oe;
endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] ram_addr,
    input logic              ram_cs_n,
    input logic              ram_we_n,
    input logic              ram_oe_n,
    input logic [DATA_W-1:0] ram_dq_out,
    input logic              ram_dq_oe
);
    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= !rst_n;
    end

    // R1: quiet memory side once a reset edge has been taken
    always @(negedge clk) begin
        if (rst_seen_q === 1'b1 && !rst_n) begin
            a_reset_quiet_r1: assert (ram_cs_n && ram_we_n && ram_oe_n && !ram_dq_oe && !rsp_valid);
        end
    end

    p_busy_not_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ram_cs_n |-> !req_ready);

    p_rsp_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_drive_in_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ram_dq_oe |-> (!ram_we_n && !ram_cs_n));

    p_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_dq_oe && $past(ram_dq_oe)) |-> $stable(ram_dq_out));

    p_data_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_we_n) |-> $past(ram_dq_oe));

    p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(ram_dq_oe && !ram_cs_n && ram_we_n && !ram_oe_n));

    p_addr_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!ram_cs_n && !$past(ram_cs_n)) |-> $stable(ram_addr));
endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .ram_addr   (ram_addr),
    .ram_cs_n   (ram_cs_n),
    .ram_we_n   (ram_we_n),
    .ram_oe_n   (ram_oe_n),
    .ram_dq_out (ram_dq_out),
    .ram_dq_oe  (ram_dq_oe)
);

// File: tb/sram_ctrl_harness.sv
module sram_ctrl_harness #(
    parameter bit OEL    = 1'b0,
    parameter int WE_LOW = 1,
    parameter int TURN   = 1,
    parameter int RD_LAT = 2,
    parameter int REC    = 1
) (
    input  logic clk,
    input  logic rst_n,
    output int   checks,
    output int   fails,
    output bit   done
);
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [19:0] req_addr  = '0;
    logic [3:0]  req_wdata = '0;
    logic        req_ready, rsp_valid;
    logic [3:0]  rsp_rdata;
    logic [19:0] ram_addr;
    logic        ram_cs_n, ram_we_n, ram_oe_n, ram_dq_oe;
    logic [3:0]  ram_dq_out;
    logic [3:0]  ram_q = 4'h0;

    sram_async_ctrl #(.WR_OE_LOW(OEL)) i_sram_async_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_we_n(ram_we_n), .ram_oe_n(ram_oe_n),
        .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_q)
    );

    function automatic logic [3:0] init_val(input logic [19:0] a);
        return a[3:0] ^ a[7:4] ^ a[19:16] ^ 4'hA;
    endfunction

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // scoreboard: driver owns the write index, monitor the read index
    logic [3:0]  exp_data [64];
    int          exp_due  [64];
    int          wp = 0;
    bit          fin = 1'b0;
    logic [3:0]  sb_mem [int];

    task automatic issue(input bit w, input logic [19:0] a, input logic [3:0] d);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        if (w) begin
            sb_mem[int'(a)] = d;
        end else begin
            exp_data[wp] = sb_mem.exists(int'(a)) ? sb_mem[int'(a)] : init_val(a);
            exp_due[wp]  = cyc + 1 + RD_LAT;
            wp = wp + 1;
        end
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        logic [19:0] lf;
        @(posedge rst_n);
        @(negedge clk);
        issue(1'b0, 20'h00000, 4'h0);            // unwritten, low boundary
        issue(1'b0, 20'hFFFFF, 4'h0);            // unwritten, high boundary
        issue(1'b1, 20'h12345, 4'h5);
        issue(1'b0, 20'h12345, 4'h0);            // read right after write
        issue(1'b1, 20'hFFFFF, 4'hF);
        issue(1'b1, 20'h00000, 4'h0);
        issue(1'b0, 20'hFFFFF, 4'h0);            // back-to-back reads
        issue(1'b0, 20'h00000, 4'h0);
        issue(1'b1, 20'h00000, 4'h9);            // write right after read
        issue(1'b0, 20'h00000, 4'h0);
        repeat (3) @(negedge clk);               // idle gap
        lf = 20'h5A5A5;
        for (int i = 0; i < 30; i++) begin
            lf = {lf[18:0], lf[19] ^ lf[16]};
            issue(lf[0], {16'h0, lf[5:2]} | (lf[1] ? 20'hF0000 : 20'h0), lf[9:6]);
        end
        repeat (10) @(negedge clk);
        fin = 1'b1;
    end

    // monitor and RAM model; all checks are made here
    logic [3:0]  ram_mem [int];
    int          rp = 0, we_run = 0, cs_low_run = 0, cs_high_run = 0, oe_high_run = 0, rd_run = 0;
    int          overlaps = 0, writes = 0;
    bit          rst_done = 0, prev_we_n = 1, prev_cs_n = 1, prev_dq_oe = 0, prev_rsp = 0, after_wr = 0;
    logic [19:0] prev_addr = '0;
    logic [3:0]  prev_dq = '0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s mode_oe_low=%0d act=%0h exp=%0h", tag, OEL, act, exp);
        end
    endtask

    initial begin
        checks = 0; fails = 0; done = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            if (cyc >= 2 && !rst_done) begin
                chk(ram_cs_n && ram_we_n && ram_oe_n, "R1 strobes", {ram_cs_n, ram_we_n, ram_oe_n}, 7);
                chk(!ram_dq_oe && !rsp_valid, "R1 drivers/valid", {ram_dq_oe, rsp_valid}, 0);
                chk(req_ready, "R1 ready", req_ready, 1);
                rst_done = 1;
            end
        end else if (!done) begin
            cs_low_run  = ram_cs_n ? 0 : cs_low_run + 1;
            oe_high_run = ram_oe_n ? oe_high_run + 1 : 0;
            we_run      = ram_we_n ? 0 : we_run + 1;
            if (!ram_cs_n) chk(!req_ready, "R2 ready while busy", req_ready, 0);
            if (!ram_cs_n && prev_cs_n) begin
                if (after_wr) chk(cs_high_run >= REC + 1, "R8 recovery", cs_high_run, REC + 1);
                if (prev_rsp) overlaps = overlaps + 1;
                after_wr = 0;
            end
            if (!ram_cs_n && !prev_cs_n) chk(ram_addr == prev_addr, "R10 addr hold", ram_addr, prev_addr);
            cs_high_run = ram_cs_n ? cs_high_run + 1 : 0;
            if (!ram_we_n) begin
                if (OEL) chk(!ram_oe_n, "R5 oe low in write", ram_oe_n, 0);
                else     chk(ram_oe_n, "R4 oe high in write", ram_oe_n, 1);
            end
            if (ram_dq_oe) begin
                chk(!ram_we_n, "R6 drive only in strobe", ram_we_n, 0);
                chk(!(!ram_cs_n && ram_we_n && !ram_oe_n), "R7 bus contention", ram_oe_n, 1);
                if (prev_dq_oe) chk(ram_dq_out == prev_dq, "R6 data stable", ram_dq_out, prev_dq);
            end
            if (ram_dq_oe && !prev_dq_oe) begin
                if (OEL) chk(we_run == TURN + 1, "R5 turnaround", we_run, TURN + 1);
                else begin
                    chk(cs_low_run == TURN + 1, "R4 turnaround", cs_low_run, TURN + 1);
                    chk(oe_high_run >= TURN + 1, "R4 oe high before drive", oe_high_run, TURN + 1);
                end
            end
            if (ram_we_n && !prev_we_n) begin
                chk(prev_dq_oe, "R6 data at end of write", prev_dq_oe, 1);
                chk(we_low_len_ok(), OEL ? "R5 strobe length" : "R4 strobe length", last_run, WE_LOW);
                ram_mem[int'(prev_addr)] = prev_dq;
                writes   = writes + 1;
                after_wr = 1;
            end
            if (rsp_valid) begin
                chk(rp < wp, "R3 unexpected response", rp, wp);
                if (rp < wp) begin
                    chk(rsp_rdata == exp_data[rp], "R9 read data", rsp_rdata, exp_data[rp]);
                    chk(cyc == exp_due[rp], "R3 read latency", cyc, exp_due[rp]);
                    rp = rp + 1;
                end
            end
            if (prev_rsp) chk(!rsp_valid, "R3 pulse width", rsp_valid, 0);
            // RAM read model: correct data only after the access time
            rd_run = (!ram_cs_n && ram_we_n && !ram_oe_n) ? rd_run + 1 : 0;
            begin
                logic [3:0] v;
                v = ram_mem.exists(int'(ram_addr)) ? ram_mem[int'(ram_addr)] : init_val(ram_addr);
                ram_q = (rd_run >= RD_LAT) ? v : ~v;
            end
            if (fin) begin
                chk(rp == wp, "R3 all responses", rp, wp);
                chk(overlaps > 0, "R2 accept next to response", overlaps, 1);
                chk(writes > 0, "R9 writes seen", writes, 1);
                done = 1;
            end
            last_run   = we_run;
            prev_we_n  = ram_we_n;
            prev_cs_n  = ram_cs_n;
            prev_dq_oe = ram_dq_oe;
            prev_dq    = ram_dq_out;
            prev_addr  = ram_addr;
            prev_rsp   = rsp_valid;
        end
    end

    int last_run = 0;
    function automatic bit we_low_len_ok();
        return last_run == WE_LOW;
    endfunction
endmodule

// File: tb/test_sram_async_ctrl.sv
module test_sram_async_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    int  c_hi, f_hi, c_lo, f_lo;
    bit  d_hi, d_lo;

    // output enable raised during writes: strobe 1 cycle
    sram_ctrl_harness #(.OEL(1'b0), .WE_LOW(1), .TURN(1), .RD_LAT(2), .REC(1)) i_mode_hi (
        .clk(clk), .rst_n(rst_n), .checks(c_hi), .fails(f_hi), .done(d_hi));
    // output enable held low during writes: strobe 2 cycles
    sram_ctrl_harness #(.OEL(1'b1), .WE_LOW(2), .TURN(1), .RD_LAT(2), .REC(1)) i_mode_lo (
        .clk(clk), .rst_n(rst_n), .checks(c_lo), .fails(f_lo), .done(d_lo));

    initial begin
        int wd;
        int total, bad;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        wd = 0;
        while (!(d_hi && d_lo) && wd < 50000) begin
            @(negedge clk);
            wd = wd + 1;
        end
        total = c_hi + c_lo;
        bad   = f_hi + f_lo;
        if (!(d_hi && d_lo)) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog expired act=%0d exp=done", wd);
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule